// File: doc/BRIEF.md
# SDRAM Command and Address Decoder

This block sits on the device side of a single-data-rate synchronous DRAM interface. On every rising clock edge it samples clock enable, chip select, the three active-low strobes (row, column, write), the bank-select bits and the address bus. It turns that sample into a one-hot command strobe and registers the address fields that go with it. For read and write it exposes the column address with bit 10 removed and the auto-precharge request. For precharge it exposes the close-every-bank request.

Alongside the decode it keeps, for each bank, an open flag and the row that was activated there. It also runs one burst counter, so that a read or write asking for auto-precharge closes its bank once the burst has run out. A read or write aimed at a bank that is not open produces a one-cycle protocol-error strobe. No burst is started for such an access.

Top module: `sdr_cmd_decoder`

## Requirements
- R1: With clock enable high and chip select low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, and 111 or 110 as no-op. `cmd_onehot` bit 0 is no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode set. Exactly one bit is high, and it reflects the pins sampled at the latest rising edge.
- R2: Chip select sampled high yields no-op whatever the strobes are. A burst already counting keeps counting, and its auto-precharge still fires on time.
- R3: Clock enable sampled low yields no-op and freezes the burst counter, so bank state is untouched for that cycle.
- R4: An activate sets the open flag of bank `ba` and stores the full 12-bit `addr` as its row in `open_rows[ba*12 +: 12]`. `cmd_bank` and `cmd_addr` show the bank and address of the latest non-no-op command.
- R5: After a read or write, `col_addr` equals {addr[11], addr[9:0]} of that command, so address bit 10 plays no part in the column.
- R6: After a read or write, `auto_pre` equals addr[10] of that command. It is low after any other command.
- R7: A precharge with addr[10] high closes all four banks and clears their rows whatever `ba` holds, and `pre_all` reads high.
- R8: A precharge with addr[10] low closes and clears only bank `ba`, and `pre_all` reads low.
- R9: An accepted read or write loads a BURST_LEN-cycle burst, and `burst_busy` stays high for BURST_LEN cycles. If addr[10] was high, the bank closes at the edge where the burst ends. A newer accepted read or write replaces the running burst and drops its pending close. An activate to the same bank in that edge wins.
- R10: A read or write to a bank whose open flag is clear raises `proto_err` for that cycle only and starts no burst.
- R11: A low `rst_n` at a rising edge closes every bank, clears all rows, stops the burst, forces `cmd_onehot` to no-op and clears `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus |
| cmd_onehot | output | 7 | Decoded command, one-hot |
| cmd_bank | output | 2 | Bank of the latest command |
| cmd_addr | output | 12 | Address of the latest command |
| col_addr | output | 11 | Column address for bursts |
| auto_pre | output | 1 | Auto-precharge requested |
| pre_all | output | 1 | Precharge targets all banks |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 48 | Stored row per bank, 12 bits each |
| proto_err | output | 1 | Access to a closed bank |
| burst_busy | output | 1 | Burst counter running |

## Verification
The bench aims at the address-bit-10 overloading. A decoder that kept bit 10 in the column, or that ignored it on precharge, shows a wrong `col_addr` or leaves banks open. It also checks the auto-precharge close lands on exactly the BURST_LEN-th edge, including while chip select is high and while clock enable is low. An off-by-one counter, or one that runs on a stopped clock, closes the bank a cycle early or late. A replaced burst must not close its bank, and an access to a closed bank must flag an error without starting a burst. A design that let either through would show a closed bank or a stuck busy flag.

// File: rtl/sdrdec_pkg.sv
// Shared types for the SDRAM command decoder.
// Assumes one-hot bit index equals the enum value.
package sdrdec_pkg;

    localparam int CMD_COUNT = 7;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

endpackage

// File: rtl/sdrdec_cmd_decode.sv
// Combinational command decode of the pins present at the next edge.
// Assumes the caller registers the result; gating by cke and cs_n is done here.
module sdrdec_cmd_decode
    import sdrdec_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the strobe triple to a command when the decoder is enabled.
    always_comb begin
        cmd = CMD_NOP;
        if (cke && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdrdec_burst_ctl.sv
// Single burst counter with optional auto-precharge close at burst end.
// Assumes at most one burst runs; a new start replaces the running one.
module sdrdec_burst_ctl #(
    parameter int BANK_W    = 2,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              start,
    input  logic              start_ap,
    input  logic [BANK_W-1:0] start_bank,
    output logic              busy,
    output logic              ap_close,
    output logic [BANK_W-1:0] ap_bank
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              ap_q;
    logic [BANK_W-1:0] bank_q;

    // Load on a new burst, count down only while the clock is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ap_q   <= 1'b0;
            bank_q <= '0;
        end else if (start) begin
            cnt_q  <= CNT_W'(BURST_LEN);
            ap_q   <= start_ap;
            bank_q <= start_bank;
        end else if (cke && cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy     = (cnt_q != '0);
    assign ap_close = cke && !start && ap_q && (cnt_q == CNT_W'(1));
    assign ap_bank  = bank_q;

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !start && cnt_q != '0) |=> $stable(cnt_q)); // R3

    AST_BURST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R9

endmodule

// File: rtl/sdrdec_bank_track.sv
// Per-bank open flag and stored row.
// Assumes activate has priority over any close aimed at the same bank in one edge.
module sdrdec_bank_track #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          act,
    input  logic [BANK_W-1:0]             act_bank,
    input  logic [ROW_W-1:0]              act_row,
    input  logic                          pre,
    input  logic                          pre_every,
    input  logic [BANK_W-1:0]             pre_bank,
    input  logic                          ap_close,
    input  logic [BANK_W-1:0]             ap_bank,
    output logic [(1<<BANK_W)-1:0]        open_q,
    output logic [(1<<BANK_W)*ROW_W-1:0]  rows_flat
);

    localparam int BANKS = 1 << BANK_W;

    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        logic [ROW_W-1:0] row_q;
        logic             hit_act;
        logic             hit_close;

        assign hit_act   = act && (act_bank == BANK_W'(i));
        assign hit_close = (pre && (pre_every || pre_bank == BANK_W'(i)))
                        || (ap_close && ap_bank == BANK_W'(i));

        // Open on activate, close and clear on precharge or auto-close.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[i] <= 1'b0;
                row_q     <= '0;
            end else if (hit_act) begin
                open_q[i] <= 1'b1;
                row_q     <= act_row;
            end else if (hit_close) begin
                open_q[i] <= 1'b0;
                row_q     <= '0;
            end
        end

        assign rows_flat[i*ROW_W +: ROW_W] = row_q;
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> open_q[$past(act_bank)]); // R4

    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && pre_every && !act) |=> (open_q == '0)); // R7

    AST_AUTO_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_close && !(act && act_bank == ap_bank)) |=> !open_q[$past(ap_bank)]); // R9

endmodule

// File: rtl/sdr_cmd_decoder.sv
// Top of the SDRAM command and address decoder.
// Registers the decoded command with its fields, tracks banks and one burst.
// Assumes ROW_W-1 > AP_BIT so the column keeps the bits above the flag bit.
module sdr_cmd_decoder
    import sdrdec_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 12,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cke,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [BANK_W-1:0]             ba,
    input  logic [ROW_W-1:0]              addr,
    output logic [CMD_COUNT-1:0]          cmd_onehot,
    output logic [BANK_W-1:0]             cmd_bank,
    output logic [ROW_W-1:0]              cmd_addr,
    output logic [ROW_W-2:0]              col_addr,
    output logic                          auto_pre,
    output logic                          pre_all,
    output logic [(1<<BANK_W)-1:0]        bank_open,
    output logic [(1<<BANK_W)*ROW_W-1:0]  open_rows,
    output logic                          proto_err,
    output logic                          burst_busy
);

    cmd_e              cmd_now;
    cmd_e              cmd_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  addr_q;
    logic              err_q;
    logic              is_access;
    logic              target_open;
    logic              burst_start;
    logic              ap_close;
    logic [BANK_W-1:0] ap_bank;

    sdrdec_cmd_decode u_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd_now)
    );

    assign is_access   = (cmd_now == CMD_RD) || (cmd_now == CMD_WR);
    assign target_open = bank_open[ba];
    assign burst_start = is_access && target_open;

    sdrdec_burst_ctl #(
        .BANK_W    (BANK_W),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .start      (burst_start),
        .start_ap   (addr[AP_BIT]),
        .start_bank (ba),
        .busy       (burst_busy),
        .ap_close   (ap_close),
        .ap_bank    (ap_bank)
    );

    sdrdec_bank_track #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (cmd_now == CMD_ACT),
        .act_bank  (ba),
        .act_row   (addr),
        .pre       (cmd_now == CMD_PRE),
        .pre_every (addr[AP_BIT]),
        .pre_bank  (ba),
        .ap_close  (ap_close),
        .ap_bank   (ap_bank),
        .open_q    (bank_open),
        .rows_flat (open_rows)
    );

    // Capture the command, its fields and the access check at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            cmd_q <= cmd_now;
            err_q <= is_access && !target_open;
            if (cmd_now != CMD_NOP) begin
                bank_q <= ba;
                addr_q <= addr;
            end
        end
    end

    assign cmd_onehot = CMD_COUNT'(1) << cmd_q;
    assign cmd_bank   = bank_q;
    assign cmd_addr   = addr_q;
    assign col_addr   = {addr_q[ROW_W-1:AP_BIT+1], addr_q[AP_BIT-1:0]};
    assign auto_pre   = addr_q[AP_BIT] && (cmd_q == CMD_RD || cmd_q == CMD_WR);
    assign pre_all    = addr_q[AP_BIT] && (cmd_q == CMD_PRE);
    assign proto_err  = err_q;

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cmd_onehot)); // R1

    AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_q == CMD_NOP)); // R2

    AST_CKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (cmd_q == CMD_NOP)); // R3

    AST_ERR_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (cmd_q == CMD_RD || cmd_q == CMD_WR)); // R10

endmodule

// File: tb/sdr_cmd_decoder_tb_top.sv
module sdr_cmd_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BL         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;

    logic [6:0]  cmd_onehot;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_addr;
    logic [10:0] col_addr;
    logic        auto_pre, pre_all, proto_err, burst_busy;
    logic [3:0]  bank_open;
    logic [47:0] open_rows;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference model state
    int m_open[4];
    int m_row[4];
    int m_cnt, m_ap, m_apbank, m_cmd, m_bank, m_addr, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .col_addr(col_addr), .auto_pre(auto_pre), .pre_all(pre_all),
        .bank_open(bank_open), .open_rows(open_rows),
        .proto_err(proto_err), .burst_busy(burst_busy)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
        m_cnt = 0; m_ap = 0; m_apbank = 0; m_cmd = 0; m_bank = 0; m_addr = 0; m_err = 0;
    endtask

    // Behavioural update for one rising edge using the driven pins.
    task automatic model_edge();
        int code, c, b, a, a10;
        bit newb;
        b = int'(ba); a = int'(addr); a10 = (a >> 10) & 1;
        code = {ras_n, cas_n, we_n};
        c = 0;
        if (cke && !cs_n) begin
            case (code)
                3: c = 1; 5: c = 2; 4: c = 3; 2: c = 4; 1: c = 5; 0: c = 6;
                default: c = 0;
            endcase
        end
        newb  = (c == 2 || c == 3) && m_open[b] != 0;
        m_err = ((c == 2 || c == 3) && m_open[b] == 0) ? 1 : 0;
        if (!newb && cke && m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0 && m_ap != 0) begin m_open[m_apbank] = 0; m_row[m_apbank] = 0; end
        end
        if (newb) begin m_cnt = BL; m_ap = a10; m_apbank = b; end
        if (c == 4) begin
            for (int i = 0; i < 4; i++)
                if (a10 != 0 || i == b) begin m_open[i] = 0; m_row[i] = 0; end
        end
        if (c == 1) begin m_open[b] = 1; m_row[b] = a; end
        m_cmd = c;
        if (c != 0) begin m_bank = b; m_addr = a; end
    endtask

    task automatic compare(input string tag);
        logic [47:0] rows;
        logic [3:0]  opn;
        for (int i = 0; i < 4; i++) begin
            rows[i*12 +: 12] = 12'(m_row[i]);
            opn[i] = (m_open[i] != 0);
        end
        chk(tag, "cmd_onehot", 64'(cmd_onehot), 64'(7'(1) << m_cmd));
        chk(tag, "cmd_bank",   64'(cmd_bank),   64'(m_bank));
        chk(tag, "cmd_addr",   64'(cmd_addr),   64'(m_addr));
        chk(tag, "col_addr",   64'(col_addr),
            64'((((m_addr >> 11) & 1) << 10) | (m_addr & 'h3FF)));
        chk(tag, "auto_pre",   64'(auto_pre),
            64'((m_cmd == 2 || m_cmd == 3) && ((m_addr >> 10) & 1) != 0));
        chk(tag, "pre_all",    64'(pre_all),
            64'(m_cmd == 4 && ((m_addr >> 10) & 1) != 0));
        chk(tag, "bank_open",  64'(bank_open),  64'(opn));
        chk(tag, "open_rows",  64'(open_rows),  64'(rows));
        chk(tag, "proto_err",  64'(proto_err),  64'(m_err));
        chk(tag, "burst_busy", 64'(burst_busy), 64'(m_cnt > 0));
    endtask

    task automatic apply(input bit k, input bit c, input bit r, input bit ca, input bit w,
                         input int b, input int a, input string tag);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w;
        ba = 2'(b); addr = 12'(a);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic nop(input string tag);              apply(1, 0, 1, 1, 1, 0, 0, tag);    endtask
    task automatic act(input int b, input int a, input string tag); apply(1, 0, 0, 1, 1, b, a, tag); endtask
    task automatic rd (input int b, input int a, input string tag); apply(1, 0, 1, 0, 1, b, a, tag); endtask
    task automatic wr (input int b, input int a, input string tag); apply(1, 0, 1, 0, 0, b, a, tag); endtask
    task automatic pre(input int b, input int a, input string tag); apply(1, 0, 0, 1, 0, b, a, tag); endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare("R11");
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        model_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R11");
        rst_n = 1'b1;

        nop("R1");
        rd(0, 'h123, "R10");                 // closed bank access
        nop("R10");                           // error lasts one cycle
        act(1, 'hABC, "R4");
        act(2, 'h123, "R4");
        act(0, 'h7FF, "R4");
        rd(1, 'h855, "R5");                   // col 0x455, no auto-precharge
        nop("R6");
        wr(2, 'h4AA, "R6");                   // auto-precharge on bank 2
        for (int i = 0; i < BL; i++) nop("R9");
        nop("R9");

        wr(0, 'hC01, "R2");                   // auto-precharge, bit 11 set
        for (int i = 0; i < BL; i++) apply(1, 1, 0, 1, 1, 3, 'h555, "R2"); // cs high, act pattern
        nop("R2");

        act(2, 'h0F0, "R3");
        rd(2, 'h400, "R3");
        for (int i = 0; i < 3; i++) apply(0, 0, 0, 1, 1, 3, 'h321, "R3"); // cke low
        for (int i = 0; i < BL + 1; i++) nop("R3");

        act(3, 'h3C3, "R9");
        rd(3, 'h7FF, "R9");
        nop("R9");
        nop("R9");
        rd(1, 'h001, "R9");                   // replaces burst, drops close
        for (int i = 0; i < BL + 2; i++) nop("R9");

        act(0, 'h111, "R8");
        pre(1, 'h000, "R8");
        nop("R8");
        pre(0, 'h400, "R7");
        pre(1, 'hFFF, "R7");
        wr(1, 'h000, "R10");

        apply(1, 0, 0, 0, 1, 1, 'h222, "R1"); // refresh
        apply(1, 0, 0, 0, 0, 2, 'h033, "R1"); // mode set
        apply(1, 0, 1, 1, 0, 3, 'h044, "R1"); // 110 treated as no-op

        act(1, 'h999, "R11");
        wr(1, 'h400, "R11");
        do_reset();
        nop("R11");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule